// File: doc/BRIEF.md
# Complementary PWM Generator with Period-Aligned Safe Disable

This block turns a single input clock into a pair of complementary pulse-width-modulated outputs. A duty value sets how long the primary output stays high in each period, and the second output is its inverse. A control value selects the counter resolution, either the full width or one bit less, and a clock prescale of one or two. Together these give base periods of 128, 256, 256 or 512 input clocks with the default 8-bit width. The control value also holds a stop flag.

Both values are written through a small synchronous write port. They are held as pending copies and move into the working copies only at a period boundary, so a change never cuts a pulse short. An active-low disable pin pulls both outputs low through a purely combinational path, with no clock edge needed. A synchronized copy of the same pin clears the internal enable. Once the stop flag or the disable pin lets go, the outputs stay low until the next period starts. After that the pulse train resumes in step with the original period grid.

Top module: `cpwm_top`

## Requirements
- R1: The base period is 2^DW input clocks with the resolution bit set and the prescale bit clear, 2^(DW+1) with both set, 2^(DW-1) with both clear, and 2^DW with resolution clear and prescale set (256, 512, 128 and 256 for DW=8).
- R2: While running, out_p is high for duty x prescale input clocks in each period and out_n is its inverse. A duty of 0 keeps out_p low and out_n high. A duty of 255 at full resolution with divide by 1 gives 255 high clocks out of 256.
- R3: At reduced resolution only the low DW-1 bits of the duty value are used, so a duty of 200 acts as 72.
- R4: A write with wr_sel=0 loads the duty value. A write with wr_sel=1 loads the control value, with bit 0 = stop, bit 1 = full resolution when 1, and bit 2 = divide by 2 when 1. A written value takes effect only at the next period boundary, and the period already under way keeps the old duty.
- R5: A stop flag that is set turns both outputs low from the next period boundary onward. Once it is cleared, the outputs resume exactly at a period boundary of the original grid.
- R6: Driving dis_n low forces out_p and out_n low at once, before any clock edge.
- R7: After dis_n returns high, both outputs stay low for the rest of that period and resume at the next period boundary.
- R8: After a synchronous reset the stop flag is set, the mode is full resolution with divide by 1, the duty is 0, and both outputs stay low until the stop flag is cleared.
- R9: out_p and out_n are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 1 | Write target: 0 = duty, 1 = control |
| wr_data | input | DW | Write data |
| dis_n | input | 1 | Asynchronous output disable, active low |
| out_p | output | 1 | Primary PWM output |
| out_n | output | 1 | Complementary PWM output |

## Verification
Errors in the prescaler or the period counter show up at once as a wrong spacing between rising edges of out_p, which is measured within one or two periods. Errors in how the duty is applied show up as a wrong number of high clocks per period, or as a loaded value leaking into the period that was already running. An error in the enable state shows up at the first period boundary after a stop or a disable is released. There the resumed rising edge must land exactly on the old grid, and out_n must not move before it.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef struct packed {
    logic div2;
    logic res8;
    logic halt;
  } ctrl_t;

  localparam int CTRL_W = 3;
  localparam ctrl_t CTRL_RESET = '{div2: 1'b0, res8: 1'b1, halt: 1'b1};
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          load,
  output logic [DW-1:0] duty_act,
  output ctrl_t         ctrl_act,
  output ctrl_t         ctrl_pend
);
  logic [DW-1:0] duty_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_pend <= '0;
      ctrl_pend <= CTRL_RESET;
    end else if (wr_en) begin
      if (wr_sel) ctrl_pend <= ctrl_t'(wr_data[CTRL_W-1:0]);
      else        duty_pend <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act <= '0;
      ctrl_act <= CTRL_RESET;
    end else if (load) begin
      duty_act <= duty_pend;
      ctrl_act <= ctrl_pend;
    end
  end

  // R4
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(duty_act) && $stable(ctrl_act)));
endmodule

// File: rtl/cpwm_prescale.sv
module cpwm_prescale (
  input  logic clk,
  input  logic rst,
  input  logic div2,
  output logic tick
);
  logic phase;

  assign tick = ~div2 | phase;

  always_ff @(posedge clk) begin
    if (rst)        phase <= 1'b0;
    else if (!div2) phase <= 1'b0;
    else            phase <= ~phase;
  end

  // R1
  tick_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (div2 && !tick) |=> tick);
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          res8,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] TOP_FULL = {CW{1'b1}};
  localparam logic [CW-1:0] TOP_HALF = TOP_FULL >> 1;

  logic [CW-1:0] top;

  assign top  = res8 ? TOP_FULL : TOP_HALF;
  assign wrap = tick && (cnt == top);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= top);
  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/cpwm_gate.sv
module cpwm_gate #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dis_n,
  input  logic [CW-1:0] cnt,
  input  logic          wrap,
  input  logic [CW-1:0] duty,
  input  logic          res8,
  input  logic          halt_act,
  input  logic          halt_pend,
  output logic          out_p,
  output logic          out_n
);
  localparam logic [CW-1:0] LOW_MASK = {1'b0, {(CW-1){1'b1}}};

  logic          sync1, dis_ok;
  logic          en;
  logic          p_q, n_q;
  logic [CW-1:0] duty_eff;
  logic          on_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1  <= 1'b0;
      dis_ok <= 1'b0;
    end else begin
      sync1  <= dis_n;
      dis_ok <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          en <= 1'b0;
    else if (!dis_ok) en <= 1'b0;
    else if (wrap)    en <= ~halt_pend;
  end

  assign duty_eff = res8 ? duty : (duty & LOW_MASK);
  assign on_phase = cnt < duty_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q <= 1'b0;
      n_q <= 1'b0;
    end else begin
      p_q <= en & on_phase;
      n_q <= en & ~on_phase;
    end
  end

  assign out_p = p_q & dis_n;
  assign out_n = n_q & dis_n;

  // R9
  never_both_high_chk: assert property (@(posedge clk) disable iff (rst)
    !(p_q && n_q));
  // R7
  en_rise_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !wrap) |=> !en);
  // R7
  dis_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
    !dis_ok |=> !en);
  // R5
  halt_blocks_en_chk: assert property (@(posedge clk) disable iff (rst)
    halt_act |-> !en);
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          dis_n,
  output logic          out_p,
  output logic          out_n
);
  logic [DW-1:0] duty_act;
  ctrl_t         ctrl_act, ctrl_pend;
  logic          tick, wrap;
  logic [DW-1:0] cnt;

  cpwm_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .load(wrap), .duty_act(duty_act), .ctrl_act(ctrl_act), .ctrl_pend(ctrl_pend)
  );

  cpwm_prescale u_pre (
    .clk(clk), .rst(rst), .div2(ctrl_act.div2), .tick(tick)
  );

  cpwm_counter #(.CW(DW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .res8(ctrl_act.res8), .cnt(cnt), .wrap(wrap)
  );

  cpwm_gate #(.CW(DW)) u_gate (
    .clk(clk), .rst(rst), .dis_n(dis_n), .cnt(cnt), .wrap(wrap),
    .duty(duty_act), .res8(ctrl_act.res8), .halt_act(ctrl_act.halt),
    .halt_pend(ctrl_pend.halt), .out_p(out_p), .out_n(out_n)
  );

  // R6
  always_comb begin
    if (!dis_n) force_low_chk: assert (!out_p && !out_n);
  end
endmodule

// File: tb/sim_cpwm_top.sv
`timescale 1ns/1ps
module sim_cpwm_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       dis_n = 1'b1;
  logic       out_p, out_n;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cpwm_top #(.DW(8)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dis_n(dis_n), .out_p(out_p), .out_n(out_n)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int n, output int hi_p, output int hi_n, output int same);
    hi_p = 0; hi_n = 0; same = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi_p += int'(out_p);
      hi_n += int'(out_n);
      if (out_p == out_n) same++;
    end
  endtask

  task automatic find_rise(output int t, output int n_hi);
    logic prev;
    prev = out_p; n_hi = 0; t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (out_p && !prev) begin
        t = cyc;
        return;
      end
      n_hi += int'(out_n);
      prev = out_p;
    end
  endtask

  // call right after find_rise: counts the period that starts at that rise
  task automatic count_period(output int hi, output int len);
    hi = 1; len = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (out_p && (hi == len)) begin
        hi++; len++;
      end else if (out_p) begin
        return;
      end else begin
        len++;
      end
    end
  endtask

  task automatic t_reset();
    int hp, hn, sm;
    measure(600, hp, hn, sm);
    check("R8 out_p low after reset", hp, 0);
    check("R8 out_n low after reset", hn, 0);
  endtask

  task automatic t_mode(input string tag, input logic [2:0] ctrl, input logic [7:0] duty,
                        input int per, input int high);
    int r1, r2, nh, hp, hn, sm;
    write_reg(1'b0, duty);
    write_reg(1'b1, {5'b0, ctrl});
    repeat (1100) @(negedge clk);
    find_rise(r1, nh);
    find_rise(r2, nh);
    check({tag, " R1 period"}, r2 - r1, per);
    measure(per, hp, hn, sm);
    check({tag, " R2 high clocks"}, hp, high);
    check({tag, " R9 complement"}, sm, 0);
  endtask

  task automatic t_extremes();
    int hp, hn, sm;
    write_reg(1'b0, 8'd0);
    write_reg(1'b1, 8'h02);
    repeat (1100) @(negedge clk);
    measure(512, hp, hn, sm);
    check("R2 duty 0 out_p", hp, 0);
    check("R2 duty 0 out_n", hn, 512);
    write_reg(1'b0, 8'd255);
    repeat (600) @(negedge clk);
    measure(256, hp, hn, sm);
    check("R2 duty 255 out_p", hp, 255);
    check("R2 duty 255 out_n", hn, 1);
  endtask

  task automatic t_duty_latch();
    int r, nh, hi1, len1, hi2, len2;
    write_reg(1'b0, 8'd200);
    write_reg(1'b1, 8'h02);
    repeat (600) @(negedge clk);
    find_rise(r, nh);
    fork
      count_period(hi1, len1);
      begin
        repeat (5) @(negedge clk);
        write_reg(1'b0, 8'd50);
      end
    join
    count_period(hi2, len2);
    check("R4 running period keeps old duty", hi1, 200);
    check("R4 new duty at boundary", hi2, 50);
    check("R4 period length unchanged", len2, 256);
  endtask

  task automatic t_stop();
    int r0, r1, nh, hp, hn, sm;
    write_reg(1'b0, 8'd128);
    write_reg(1'b1, 8'h02);
    repeat (600) @(negedge clk);
    find_rise(r0, nh);
    write_reg(1'b1, 8'h03);
    repeat (300) @(negedge clk);
    measure(300, hp, hn, sm);
    check("R5 stop out_p low", hp, 0);
    check("R5 stop out_n low", hn, 0);
    write_reg(1'b1, 8'h02);
    find_rise(r1, nh);
    check("R5 resume on period grid", (r1 - r0) % 256, 0);
    check("R5 out_n quiet before resume", nh, 0);
  endtask

  task automatic t_disable();
    int r0, r1, nh, hp, hn, sm, pa, na;
    write_reg(1'b0, 8'd128);
    write_reg(1'b1, 8'h02);
    repeat (600) @(negedge clk);
    find_rise(r0, nh);
    repeat (20) @(negedge clk);
    #0.5 dis_n = 1'b0;
    #0.5 begin pa = int'(out_p); na = int'(out_n); end
    check("R6 out_p forced low before edge", pa, 0);
    check("R6 out_n forced low before edge", na, 0);
    measure(50, hp, hn, sm);
    check("R6 out_p low while disabled", hp, 0);
    check("R6 out_n low while disabled", hn, 0);
    dis_n = 1'b1;
    find_rise(r1, nh);
    check("R7 resume at next boundary", r1 - r0, 256);
    check("R7 out_n low until boundary", nh, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mode("8bit/div1", 3'b010, 8'd100, 256, 100);
    t_mode("8bit/div2", 3'b110, 8'd100, 512, 200);
    t_mode("7bit/div1 R3", 3'b000, 8'd200, 128, 72);
    t_mode("7bit/div2 R3", 3'b100, 8'd40, 256, 80);
    t_extremes();
    t_duty_latch();
    t_stop();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule